// File: doc/BRIEF.md
# Two-Entry Audio Playback Queue

This block is the front end of an audio playback engine. Software queues up to two buffers, each given as a start address and a byte length. The buffer at the head of the queue is handed downstream through a start strobe with its address and length. The block then counts down for as long as that buffer takes to play. When the countdown ends it removes the buffer, raises an interrupt pulse and, if a second buffer is waiting, starts that buffer on the next cycle.

The play time of a buffer is computed from its length and a rate register. Each four bytes form one stereo sample. One sample lasts `(rate + 1) * DAC_DIV` system clocks, where `DAC_DIV` is the fixed ratio between the system clock and the converter reference clock. A buffer with zero length finishes in the same cycle that it starts. Fetching and converting the sample data happen in a separate block downstream.

Top module: `audio_dma_queue`

## Requirements
- R1: While reset is held and in the cycle after it is released, `irq` and `startPulse` are low and `dmaStatus` is zero.
- R2: Writing the length register pushes one entry that holds the most recently written address. When the entry starts, `startPulse` is high for one cycle, and in that cycle `curAddr` and `curLen` show that entry's address and length.
- R3: For an entry of length L started with rate value R, `irq` rises exactly `(L/4)*(R+1)*DAC_DIV + 1` cycles after the cycle in which `startPulse` is high. L/4 uses integer division, so lengths 1 to 3 give 1 cycle.
- R4: An entry of length zero raises `irq` in the same cycle as its `startPulse`.
- R5: Entries play in the order they were pushed. The read slot alternates between the two storage slots after each completion.
- R6: `dmaStatus` bit 31 and bit 0 are both 1 exactly when two entries are queued. Bit 30 is 1 whenever at least one entry is queued. Every other bit reads 0.
- R7: A length write while two entries are queued is dropped. It creates no entry and causes no later start.
- R8: When an entry completes and another entry is waiting, the waiting entry's `startPulse` comes in the cycle after the `irq` cycle.
- R9: After any completion, the queue is not full in the cycle where `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrWrEn | input | 1 | Load the pending buffer address |
| addrWrData | input | ADDR_W | Buffer address |
| lenWrEn | input | 1 | Write the length and push an entry |
| lenWrData | input | LEN_W | Buffer length in bytes |
| rateWrEn | input | 1 | Load the rate register |
| rateWrData | input | RATE_W | Rate divider value R |
| irq | output | 1 | High for one cycle per completed entry |
| startPulse | output | 1 | High for one cycle when an entry starts |
| curAddr | output | ADDR_W | Address of the entry most recently started |
| curLen | output | LEN_W | Length of the entry most recently started |
| dmaStatus | output | 32 | Bit 31 and bit 0 = full, bit 30 = busy |

## Verification
The assertions assume the following about the inputs:
- The rate register holds its value while an entry is being started. The countdown length is fixed at the start, so a later change does not move the measured interrupt time.
- The address register is written before the length write that uses it, never in the same cycle.

The stimulus keeps to both rules. Every register write lasts one cycle and is driven on the falling edge, and the rate and address are always written in cycles before the length write. In the queue-full sequence, pushes are made while the first entry is still counting down. This makes the full condition and the dropped push happen at known points inside a long play window.

// File: rtl/adq_pkg.sv
package adq_pkg;
  localparam int QDEPTH = 2;

  typedef struct packed {
    logic push;     // store a new entry in slot wrSel
    logic wrSel;    // slot that receives the push
    logic rdSel;    // slot at the head of the queue
    logic capture;  // latch the head entry onto curAddr and curLen
    logic load;     // load the countdown from the head entry
    logic park;     // return the countdown to its idle value
    logic dec;      // step the countdown down by one
  } dpCtrlT;
endpackage

// File: rtl/adq_datapath.sv
module adq_datapath
  import adq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 18,
  parameter int RATE_W  = 14,
  parameter int DAC_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctl,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateWrData,
  output logic              headLenZero,
  output logic              cntZero,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  curLen
);
  localparam int SAMP_W = LEN_W - 2;
  localparam int CNT_W  = SAMP_W + RATE_W + 1 + $clog2(DAC_DIV + 1);

  logic [ADDR_W-1:0] pendAddr;
  logic [RATE_W-1:0] rateReg;
  logic [ADDR_W-1:0] entAddr [QDEPTH];
  logic [LEN_W-1:0]  entLen  [QDEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;
  logic [RATE_W:0]   ratePlusOne;
  logic [LEN_W-1:0]  headLen;
  logic [ADDR_W-1:0] headAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      rateReg  <= '0;
    end else begin
      if (addrWrEn) pendAddr <= addrWrData;
      if (rateWrEn) rateReg  <= rateWrData;
    end
  end

  for (genvar e = 0; e < QDEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entAddr[e] <= '0;
        entLen[e]  <= '0;
      end else if (ctl.push && (ctl.wrSel == 1'(e))) begin
        entAddr[e] <= pendAddr;
        entLen[e]  <= lenWrData;
      end
    end
  end

  assign headLen     = entLen[ctl.rdSel];
  assign headAddr    = entAddr[ctl.rdSel];
  assign headLenZero = (headLen == '0);

  assign ratePlusOne = {1'b0, rateReg} + {{RATE_W{1'b0}}, 1'b1};
  assign loadVal     = CNT_W'(headLen[LEN_W-1:2]) * CNT_W'(ratePlusOne)
                     * CNT_W'(DAC_DIV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (ctl.park) begin
      cnt <= '1;
    end else if (ctl.load) begin
      cnt <= loadVal;
    end else if (ctl.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      curLen  <= '0;
    end else if (ctl.capture) begin
      curAddr <= headAddr;
      curLen  <= headLen;
    end
  end
endmodule

// File: rtl/adq_control.sv
module adq_control
  import adq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lenWrEn,
  input  logic       headLenZero,
  input  logic       cntZero,
  output dpCtrlT     ctl,
  output logic       irq,
  output logic       startPulse,
  output logic [1:0] queueCount
);
  logic rdIdx;
  logic active;
  logic pushOk;
  logic startNow;
  logic finish;
  logic pop;

  assign pushOk   = lenWrEn && (queueCount != 2'd2);
  assign startNow = (queueCount != 2'd0) && !active;
  assign finish   = active && cntZero;
  assign pop      = finish || (startNow && headLenZero);

  always_comb begin
    ctl         = '0;
    ctl.push    = pushOk;
    ctl.wrSel   = rdIdx ^ (queueCount == 2'd1);
    ctl.rdSel   = rdIdx;
    ctl.capture = startNow;
    ctl.load    = startNow && !headLenZero;
    ctl.park    = finish;
    ctl.dec     = active && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queueCount <= 2'd0;
      rdIdx      <= 1'b0;
      active     <= 1'b0;
      irq        <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      queueCount <= queueCount + {1'b0, pushOk} - {1'b0, pop};
      if (pop) rdIdx <= ~rdIdx;
      if (finish) active <= 1'b0;
      else if (startNow && !headLenZero) active <= 1'b1;
      irq        <= pop;
      startPulse <= startNow;
    end
  end
endmodule

// File: rtl/audio_dma_queue.sv
module audio_dma_queue
  import adq_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 18,
  parameter int RATE_W  = 14,
  parameter int DAC_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateWrData,
  output logic              irq,
  output logic              startPulse,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LEN_W-1:0]  curLen,
  output logic [31:0]       dmaStatus
);
  dpCtrlT     ctl;
  logic       headLenZero;
  logic       cntZero;
  logic [1:0] queueCount;

  adq_control u_ctl (
    .clk(clk), .rstN(rstN), .lenWrEn(lenWrEn), .headLenZero(headLenZero),
    .cntZero(cntZero), .ctl(ctl), .irq(irq), .startPulse(startPulse),
    .queueCount(queueCount)
  );

  adq_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W), .DAC_DIV(DAC_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrWrEn(addrWrEn),
    .addrWrData(addrWrData), .lenWrData(lenWrData), .rateWrEn(rateWrEn),
    .rateWrData(rateWrData), .headLenZero(headLenZero), .cntZero(cntZero),
    .curAddr(curAddr), .curLen(curLen)
  );

  always_comb begin
    dmaStatus     = '0;
    dmaStatus[31] = (queueCount == 2'd2);
    dmaStatus[30] = (queueCount != 2'd0);
    dmaStatus[0]  = (queueCount == 2'd2);
  end
endmodule

// File: rtl/adq_checker.sv
module adq_checker #(
  parameter int LEN_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic             startPulse,
  input logic [31:0]      dmaStatus,
  input logic [LEN_W-1:0] curLen,
  input logic [1:0]       queueCount
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= 2'd2);

  p_status_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dmaStatus[0] == dmaStatus[31]) && (!dmaStatus[31] || dmaStatus[30])
    && (dmaStatus[29:1] == '0));

  p_start_needs_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(dmaStatus[30]));

  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && curLen == '0) |-> irq);

  p_pop_frees_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !dmaStatus[31]);
endmodule

bind audio_dma_queue adq_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .irq(irq), .startPulse(startPulse),
  .dmaStatus(dmaStatus), .curLen(curLen), .queueCount(queueCount)
);

// File: tb/tb_audio_dma_queue.sv
module tb_audio_dma_queue;
  localparam int ADDR_W = 24, LEN_W = 18, RATE_W = 14, DAC_DIV = 2;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [RATE_W-1:0] rate;
    logic [15:0]       expCycles;  // start cycle to irq, per R3/R4
  } vecT;

  localparam vecT VEC [NVEC] = '{
    '{24'h000100, 18'd16, 14'd3, 16'd33},
    '{24'h000204, 18'd4,  14'd0, 16'd3},
    '{24'h000308, 18'd2,  14'd5, 16'd1},
    '{24'h00040C, 18'd0,  14'd7, 16'd0},
    '{24'h000510, 18'd40, 14'd1, 16'd41},
    '{24'h000614, 18'd8,  14'd9, 16'd41}
  };

  logic clk = 0, rstN = 0;
  logic addrWrEn = 0, lenWrEn = 0, rateWrEn = 0;
  logic [ADDR_W-1:0] addrWrData = '0;
  logic [LEN_W-1:0]  lenWrData = '0;
  logic [RATE_W-1:0] rateWrData = '0;
  logic irq, startPulse;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  curLen;
  logic [31:0] dmaStatus;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_dma_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W),
                    .DAC_DIV(DAC_DIV)) dut (.*);

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrRate(input logic [RATE_W-1:0] v);
    @(negedge clk); rateWrEn = 1; rateWrData = v;
    @(negedge clk); rateWrEn = 0;
  endtask
  task automatic wrAddr(input logic [ADDR_W-1:0] v);
    @(negedge clk); addrWrEn = 1; addrWrData = v;
    @(negedge clk); addrWrEn = 0;
  endtask
  task automatic wrLen(input logic [LEN_W-1:0] v);
    @(negedge clk); lenWrEn = 1; lenWrData = v;
    @(negedge clk); lenWrEn = 0;
  endtask

  task automatic waitStart(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (startPulse) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic waitIrq(output int n);
    n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    repeat (3) @(negedge clk);
    check(!irq && !startPulse && dmaStatus == 0, "R1 in reset",
          {irq, startPulse, dmaStatus}, 0);
    rstN = 1;
    @(negedge clk);
    check(!irq && !startPulse && dmaStatus == 0, "R1 after release",
          {irq, startPulse, dmaStatus}, 0);

    for (int v = 0; v < NVEC; v++) begin
      wrRate(VEC[v].rate);
      wrAddr(VEC[v].addr);
      wrLen(VEC[v].len);
      waitStart(seen);
      check(seen && curAddr == VEC[v].addr && curLen == VEC[v].len,
            "R2 start entry", {curAddr, curLen}, {VEC[v].addr, VEC[v].len});
      waitIrq(n);
      check(n == int'(VEC[v].expCycles), "R3/R4 play cycles", n,
            VEC[v].expCycles);
      repeat (3) @(negedge clk);
      check(dmaStatus == 0 && !irq, "R6 idle status", dmaStatus, 0);
    end

    // Queue full, then a dropped push (rate 9: 2000+ cycles per entry).
    wrRate(14'd9);
    wrAddr(24'hA1); wrLen(18'd400);
    wrAddr(24'hA2); wrLen(18'd404);
    check(dmaStatus == 32'hC000_0001, "R6 full flags", dmaStatus,
          32'hC000_0001);
    wrAddr(24'hA3); wrLen(18'd408);
    check(dmaStatus == 32'hC000_0001, "R7 still two queued", dmaStatus,
          32'hC000_0001);
    waitIrq(n);
    check(dmaStatus == 32'h4000_0000, "R9 busy not full after pop",
          dmaStatus, 32'h4000_0000);
    check(!startPulse, "R8 no start in irq cycle", startPulse, 0);
    @(negedge clk);
    check(startPulse, "R8 next start one cycle after irq", startPulse, 1);
    check(curAddr == 24'hA2 && curLen == 18'd404, "R5 push order",
          {curAddr, curLen}, {24'hA2, 18'd404});
    @(negedge clk);
    waitIrq(n);
    check(n == 101 * 10 * 2, "R3 second entry time", n + 1, 101 * 10 * 2 + 1);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (startPulse) seen = 1;
    end
    check(!seen && dmaStatus == 0, "R7 dropped push never starts",
          {seen, dmaStatus}, 0);

    // Two zero-length entries back to back: slots alternate (R5).
    wrAddr(24'hB1); wrLen(18'd0);
    wrAddr(24'hB2); wrLen(18'd0);
    wrAddr(24'hB3); wrLen(18'd12);
    waitStart(seen);
    check(seen && curAddr == 24'hB3 && curLen == 18'd12,
          "R5 slot alternation", {curAddr, curLen}, {24'hB3, 18'd12});
    waitIrq(n);
    check(n == 3 * 10 * 2 + 1, "R3 after alternation", n, 3 * 10 * 2 + 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule